// File: doc/BRIEF.md
# Accumulator ALU with Carry, Zero, Sign and Parity Status

This block is the arithmetic and logic heart of a small accumulator datapath. It holds an accumulator register and four status bits (carry, zero, sign, parity). On each clock edge where a request is presented, it combines the accumulator with an operand supplied by the surrounding datapath. The operand may come from a register file, from memory or from an immediate field; the block does not care which. It then writes the result and the affected status bits back into its own registers. The status bits stay stable between operations, so a branch unit can test them later.

Seventeen operations are supported, selected by a 5-bit code:

| Code | Operation | Code | Operation |
|------|-----------|------|-----------|
| 0 | add | 9 | decrement |
| 1 | add with carry | 10 | invert accumulator |
| 2 | subtract | 11 | invert carry |
| 3 | subtract with borrow | 12 | set carry |
| 4 | AND | 13 | rotate left, old top bit into bit 0 and carry |
| 5 | XOR | 14 | rotate right, old bit 0 into top bit and carry |
| 6 | OR | 15 | rotate left through carry |
| 7 | compare | 16 | rotate right through carry |
| 8 | increment | | |

Codes 17 to 31 are unused. Operand fetch and decimal adjustment belong to other blocks.

The block has no sequencing state of its own. Every accepted operation completes in the cycle it is accepted, so the only stored state is the accumulator and the status register. The control is a single decode step: one combinational process selects the result and which status bits to update, and one register process commits them.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst_n` is low, the accumulator and all four status bits are 0.
- R2: When `op_valid` is low, or when `op_code` is 17 to 31, the accumulator and all status bits keep their values.
- R3: Add (code 0) and add with carry (code 1) write A + operand, plus the old carry for code 1, modulo 256. Carry becomes the carry out of bit 7.
- R4: Subtract (code 2) and subtract with borrow (code 3) write A − operand, minus the old carry for code 3, modulo 256. Carry becomes 1 exactly when the subtrahend (operand, plus the old carry for code 3) exceeds A as unsigned numbers.
- R5: Compare (code 7) sets carry, zero, sign and parity exactly as subtract (code 2) would, and leaves the accumulator unchanged.
- R6: AND (code 4), XOR (code 5) and OR (code 6) write the bitwise result and clear carry.
- R7: Increment (code 8) and decrement (code 9) write A+1 and A−1 modulo 256. They update zero, sign and parity and leave carry unchanged.
- R8: For codes 0 to 9, zero is 1 when the result is 0, sign equals bit 7 of the result, and parity is 1 when the result has an even number of ones. For compare, the result is the difference.
- R9: Invert accumulator (code 10) writes the bitwise complement of A and leaves all four status bits unchanged.
- R10: Invert carry (code 11) toggles carry and set carry (code 12) forces it to 1. Both leave the accumulator, zero, sign and parity unchanged.
- R11: Rotate left (code 13) shifts A up one place, copying old bit 7 into both bit 0 and carry. Rotate right (code 14) shifts A down one place, copying old bit 0 into both bit 7 and carry. Zero, sign and parity are unchanged.
- R12: Rotate left through carry (code 15) loads bit 0 from the old carry and carry from old bit 7. Rotate right through carry (code 16) loads bit 7 from the old carry and carry from old bit 0. Zero, sign and parity are unchanged.
- R13: An operation accepted on a rising edge is visible on the outputs right after that edge. A following operation on the next edge uses the updated accumulator and carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Execute `op_code` on this edge |
| op_code | input | 5 | Operation select, codes 0 to 16 as listed above |
| operand | input | DATA_W | Second operand (register, memory or immediate) |
| acc | output | DATA_W | Accumulator contents |
| cy_flag | output | 1 | Carry / borrow status |
| zero_flag | output | 1 | Result was zero |
| sign_flag | output | 1 | Top bit of the result |
| par_flag | output | 1 | Result had even parity |

## Verification
The two functions that share a cycle are the status update and the accumulator write-back. They are bound together by the carry path: the carry written by one operation is consumed on the very next edge by add with carry, subtract with borrow or a rotate through carry. Compare writes status while withholding the accumulator write in that same edge. The bench provokes this with long back-to-back runs of random operations, in which carry producers and consumers follow each other with no idle cycle. It adds directed chains such as add-overflow then add-with-carry, and compare directly after a write. After every edge it judges the accumulator and all four status bits against a bench model that advances one operation per accepted edge.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

    localparam int OP_W     = 5;
    localparam int OP_COUNT = 17;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_AND = 5'd4,
        OP_XOR = 5'd5,
        OP_OR  = 5'd6,
        OP_CMP = 5'd7,
        OP_INC = 5'd8,
        OP_DEC = 5'd9,
        OP_CMA = 5'd10,
        OP_CMC = 5'd11,
        OP_STC = 5'd12,
        OP_RLC = 5'd13,
        OP_RRC = 5'd14,
        OP_RAL = 5'd15,
        OP_RAR = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_XOR = 2'd1,
        LG_OR  = 2'd2,
        LG_NOT = 2'd3
    } logic_sel_e;

endpackage

// File: rtl/acc_alu_addsub.sv
`timescale 1ns/1ps
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         carry_in,
    output logic [W-1:0] res,
    output logic         carry_out
);
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   sum;

    // Subtraction as a + ~b + ~borrow_in; the adder carry is then the
    // inverse of the borrow, so it is flipped back on the way out.
    always_comb begin
        b_eff     = sub ? ~b : b;
        c_eff     = sub ? ~carry_in : carry_in;
        sum       = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        res       = sum[W-1:0];
        carry_out = sum[W] ^ sub;
    end
endmodule

// File: rtl/acc_alu_logic.sv
`timescale 1ns/1ps
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (sel)
            LG_AND:  res = a & b;
            LG_XOR:  res = a ^ b;
            LG_OR:   res = a | b;
            LG_NOT:  res = ~a;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/acc_alu_rotate.sv
`timescale 1ns/1ps
module acc_alu_rotate #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         carry_in,
    input  logic         right,
    input  logic         thru,
    output logic [W-1:0] res,
    output logic         carry_out
);
    logic fill_left;
    logic fill_right;

    always_comb begin
        fill_left  = thru ? carry_in : a[W-1];
        fill_right = thru ? carry_in : a[0];
        if (right) begin
            res       = {fill_right, a[W-1:1]};
            carry_out = a[0];
        end else begin
            res       = {a[W-2:0], fill_left};
            carry_out = a[W-1];
        end
    end
endmodule

// File: rtl/acc_alu_status.sv
`timescale 1ns/1ps
module acc_alu_status #(
    parameter int W = 8
) (
    input  logic [W-1:0] res,
    output logic         is_zero,
    output logic         is_neg,
    output logic         even_par
);
    always_comb begin
        is_zero  = (res == '0);
        is_neg   = res[W-1];
        even_par = ~^res;
    end
endmodule

// File: rtl/acc_alu_core.sv
`timescale 1ns/1ps
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc,
    output logic              cy_flag,
    output logic              zero_flag,
    output logic              sign_flag,
    output logic              par_flag
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Unit steering
    logic [DATA_W-1:0] as_b;
    logic              as_sub;
    logic              as_cin;
    logic [DATA_W-1:0] as_res;
    logic              as_cout;
    logic_sel_e        lg_sel;
    logic [DATA_W-1:0] lg_res;
    logic              rt_right;
    logic              rt_thru;
    logic [DATA_W-1:0] rt_res;
    logic              rt_cout;

    // Commit controls
    logic [DATA_W-1:0] res_val;
    logic              wr_acc;
    logic              upd_zsp;
    logic              upd_cy;
    logic              cy_val;
    logic              st_zero;
    logic              st_neg;
    logic              st_par;

    always_comb begin
        as_b     = operand;
        as_sub   = 1'b0;
        as_cin   = 1'b0;
        lg_sel   = LG_AND;
        rt_right = 1'b0;
        rt_thru  = 1'b0;
        unique case (op_code)
            OP_ADC:         as_cin = cy_flag;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin
                as_sub = 1'b1;
                as_cin = cy_flag;
            end
            OP_INC:         as_b = ONE;
            OP_DEC: begin
                as_b   = ONE;
                as_sub = 1'b1;
            end
            OP_XOR:         lg_sel = LG_XOR;
            OP_OR:          lg_sel = LG_OR;
            OP_CMA:         lg_sel = LG_NOT;
            OP_RRC:         rt_right = 1'b1;
            OP_RAL:         rt_thru = 1'b1;
            OP_RAR: begin
                rt_right = 1'b1;
                rt_thru  = 1'b1;
            end
            default: ;
        endcase
    end

    acc_alu_addsub #(.W(DATA_W)) u_addsub (
        .a         (acc),
        .b         (as_b),
        .sub       (as_sub),
        .carry_in  (as_cin),
        .res       (as_res),
        .carry_out (as_cout)
    );

    acc_alu_logic #(.W(DATA_W)) u_logic (
        .a   (acc),
        .b   (operand),
        .sel (lg_sel),
        .res (lg_res)
    );

    acc_alu_rotate #(.W(DATA_W)) u_rotate (
        .a         (acc),
        .carry_in  (cy_flag),
        .right     (rt_right),
        .thru      (rt_thru),
        .res       (rt_res),
        .carry_out (rt_cout)
    );

    // Result selection and update mask
    always_comb begin
        res_val = acc;
        wr_acc  = 1'b0;
        upd_zsp = 1'b0;
        upd_cy  = 1'b0;
        cy_val  = cy_flag;
        unique case (op_code)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                res_val = as_res;
                wr_acc  = 1'b1;
                upd_zsp = 1'b1;
                upd_cy  = 1'b1;
                cy_val  = as_cout;
            end
            OP_CMP: begin
                res_val = as_res;
                upd_zsp = 1'b1;
                upd_cy  = 1'b1;
                cy_val  = as_cout;
            end
            OP_AND, OP_XOR, OP_OR: begin
                res_val = lg_res;
                wr_acc  = 1'b1;
                upd_zsp = 1'b1;
                upd_cy  = 1'b1;
                cy_val  = 1'b0;
            end
            OP_INC, OP_DEC: begin
                res_val = as_res;
                wr_acc  = 1'b1;
                upd_zsp = 1'b1;
            end
            OP_CMA: begin
                res_val = lg_res;
                wr_acc  = 1'b1;
            end
            OP_CMC: begin
                upd_cy = 1'b1;
                cy_val = ~cy_flag;
            end
            OP_STC: begin
                upd_cy = 1'b1;
                cy_val = 1'b1;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                res_val = rt_res;
                wr_acc  = 1'b1;
                upd_cy  = 1'b1;
                cy_val  = rt_cout;
            end
            default: ;
        endcase
    end

    acc_alu_status #(.W(DATA_W)) u_status (
        .res      (res_val),
        .is_zero  (st_zero),
        .is_neg   (st_neg),
        .even_par (st_par)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc       <= '0;
            cy_flag   <= 1'b0;
            zero_flag <= 1'b0;
            sign_flag <= 1'b0;
            par_flag  <= 1'b0;
        end else if (op_valid) begin
            if (wr_acc) acc <= res_val;
            if (upd_cy) cy_flag <= cy_val;
            if (upd_zsp) begin
                zero_flag <= st_zero;
                sign_flag <= st_neg;
                par_flag  <= st_par;
            end
        end
    end

    // Checks
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code >= OP_W'(OP_COUNT)) |=> ($stable(acc) && $stable(cy_flag) && $stable(zero_flag) && $stable(sign_flag) && $stable(par_flag))); // R2

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMP) |=> $stable(acc)); // R5

    AST_LOGIC_CLEARS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_AND || op_code == OP_XOR || op_code == OP_OR)) |=> !cy_flag); // R6

    AST_INCDEC_KEEP_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> $stable(cy_flag)); // R7

    AST_ZSP_FOLLOW_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= OP_DEC && op_code != OP_CMP) |=> (zero_flag == (acc == '0) && sign_flag == acc[DATA_W-1] && par_flag == ~^acc)); // R8

    AST_CMA_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMA) |=> (acc == ~$past(acc) && $stable(cy_flag) && $stable(zero_flag))); // R9

    AST_CMC_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMC) |=> (cy_flag != $past(cy_flag) && $stable(acc))); // R10

    AST_STC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_STC) |=> (cy_flag && $stable(acc))); // R10

    AST_RLC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_RLC) |=> (acc == {$past(acc[DATA_W-2:0]), $past(acc[DATA_W-1])} && cy_flag == $past(acc[DATA_W-1]))); // R11

    AST_RAL_THRU_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_RAL) |=> (acc == {$past(acc[DATA_W-2:0]), $past(cy_flag)} && cy_flag == $past(acc[DATA_W-1]))); // R12

endmodule

// File: tb/acc_alu_core_tb.sv
`timescale 1ns/1ps
module acc_alu_core_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [4:0] op_code;
    logic [7:0] operand;
    logic [7:0] acc;
    logic       cy_flag, zero_flag, sign_flag, par_flag;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [7:0] m_acc;
    logic       m_cy, m_z, m_s, m_p;

    always #2.5 clk = ~clk;

    acc_alu_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .operand   (operand),
        .acc       (acc),
        .cy_flag   (cy_flag),
        .zero_flag (zero_flag),
        .sign_flag (sign_flag),
        .par_flag  (par_flag)
    );

    function automatic string tag_of(input logic v, input logic [4:0] op);
        if (!v) return "R2";
        case (op)
            5'd0, 5'd1:   return "R3";
            5'd2, 5'd3:   return "R4";
            5'd7:         return "R5";
            5'd4, 5'd5, 5'd6: return "R6";
            5'd8, 5'd9:   return "R7";
            5'd10:        return "R9";
            5'd11, 5'd12: return "R10";
            5'd13, 5'd14: return "R11";
            5'd15, 5'd16: return "R12";
            default:      return "R2";
        endcase
    endfunction

    task automatic set_zsp(input logic [7:0] r);
        m_z = (r == 8'h00);
        m_s = r[7];
        m_p = ~^r;
    endtask

    task automatic model_step(input logic [4:0] op, input logic [7:0] b);
        logic [8:0] t;
        logic [7:0] r;
        case (op)
            5'd0, 5'd1: begin
                t = {1'b0, m_acc} + {1'b0, b} + ((op == 5'd1) ? {8'h00, m_cy} : 9'h000);
                m_acc = t[7:0]; m_cy = t[8]; set_zsp(m_acc);
            end
            5'd2, 5'd3, 5'd7: begin
                t = {1'b0, b} + ((op == 5'd3) ? {8'h00, m_cy} : 9'h000);
                r = m_acc - t[7:0];
                m_cy = (t > {1'b0, m_acc});
                set_zsp(r);
                if (op != 5'd7) m_acc = r;
            end
            5'd4: begin m_acc = m_acc & b; m_cy = 1'b0; set_zsp(m_acc); end
            5'd5: begin m_acc = m_acc ^ b; m_cy = 1'b0; set_zsp(m_acc); end
            5'd6: begin m_acc = m_acc | b; m_cy = 1'b0; set_zsp(m_acc); end
            5'd8: begin m_acc = m_acc + 8'd1; set_zsp(m_acc); end
            5'd9: begin m_acc = m_acc - 8'd1; set_zsp(m_acc); end
            5'd10: m_acc = ~m_acc;
            5'd11: m_cy = ~m_cy;
            5'd12: m_cy = 1'b1;
            5'd13: begin m_cy = m_acc[7]; m_acc = {m_acc[6:0], m_acc[7]}; end
            5'd14: begin m_cy = m_acc[0]; m_acc = {m_acc[0], m_acc[7:1]}; end
            5'd15: begin r = {m_acc[6:0], m_cy}; m_cy = m_acc[7]; m_acc = r; end
            5'd16: begin r = {m_cy, m_acc[7:1]}; m_cy = m_acc[0]; m_acc = r; end
            default: ;
        endcase
    endtask

    task automatic check(input string tag);
        checks++;
        if ({acc, cy_flag, zero_flag, sign_flag, par_flag} !== {m_acc, m_cy, m_z, m_s, m_p}) begin
            errors++;
            $display("FAIL %s: got acc=%h cy=%b z=%b s=%b p=%b expected acc=%h cy=%b z=%b s=%b p=%b",
                     tag, acc, cy_flag, zero_flag, sign_flag, par_flag, m_acc, m_cy, m_z, m_s, m_p);
        end
    endtask

    // Called at a falling edge; drives, lets one rising edge pass, checks at the next falling edge.
    task automatic apply(input logic v, input logic [4:0] op, input logic [7:0] b, input string tag);
        op_valid = v;
        op_code  = op;
        operand  = b;
        if (v) model_step(op, b);
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0A1C));
        rst_n    = 1'b0;
        op_valid = 1'b1;
        op_code  = 5'd12;
        operand  = 8'hA5;
        m_acc = 8'h00; m_cy = 1'b0; m_z = 1'b0; m_s = 1'b0; m_p = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;

        // Directed corner cases, back to back
        apply(1'b1, 5'd4,  8'h00, "R6 and clears");
        apply(1'b1, 5'd6,  8'h80, "R8 sign");
        apply(1'b1, 5'd0,  8'h80, "R3 wrap to zero");
        apply(1'b1, 5'd1,  8'h05, "R13 carry chained into adc");
        apply(1'b1, 5'd2,  8'h07, "R4 borrow");
        apply(1'b1, 5'd3,  8'hFE, "R4 sbb to zero");
        apply(1'b1, 5'd7,  8'h00, "R5 compare equal");
        apply(1'b1, 5'd6,  8'h42, "R6 or");
        apply(1'b1, 5'd7,  8'h43, "R5 compare borrow");
        apply(1'b1, 5'd6,  8'hFF, "R6 or all ones");
        apply(1'b1, 5'd12, 8'h00, "R10 set carry");
        apply(1'b1, 5'd8,  8'h00, "R7 increment wrap keeps carry");
        apply(1'b1, 5'd11, 8'h00, "R10 invert carry");
        apply(1'b1, 5'd9,  8'h00, "R7 decrement wrap keeps carry");
        apply(1'b1, 5'd10, 8'h00, "R9 invert acc keeps flags");
        apply(1'b1, 5'd12, 8'h00, "R10 set carry again");
        apply(1'b1, 5'd15, 8'h00, "R12 rotate left through carry");
        apply(1'b1, 5'd16, 8'h00, "R12 rotate right through carry");
        apply(1'b1, 5'd6,  8'h81, "R6 or pattern");
        apply(1'b1, 5'd13, 8'h00, "R11 rotate left");
        apply(1'b1, 5'd14, 8'h00, "R11 rotate right");
        apply(1'b1, 5'd5,  8'h02, "R8 odd parity");
        apply(1'b1, 5'd31, 8'h55, "R2 unused code");
        apply(1'b0, 5'd0,  8'h55, "R2 not valid");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic       v;
            logic [4:0] op;
            logic [7:0] b;
            v  = ($urandom_range(0, 9) != 0);
            op = 5'($urandom_range(0, 19));
            b  = 8'($urandom);
            apply(v, op, b, tag_of(v, op));
        end

        finish_run();
    end

endmodule